// File: doc/BRIEF.md
# Framed Manchester Serial Transmitter

This block sends a 16-bit sample over a single wire, again and again, as a Manchester-encoded serial frame. A frame opens with a long run of zero bits. One start bit of value 1 follows, and then the sample itself, most significant bit first. Because the preamble is long, a receiver that has lost lock can find the next start bit and settle again.

The block takes a sample at every frame boundary and raises a one-cycle pulse to mark it. Timing comes from a strobe, `half_en`, that the surrounding logic asserts at twice the bit rate. A half-bit phase register toggles on that strobe. The output is the XOR of two registers, the phase and the current data bit, which change on the same clock edge, so the line carries no glitches. Each bit holds the line high for exactly one of its two halves, so the encoded stream averages a 50% duty cycle and can be transformer coupled.

The sequencer has three states:
- `S_PRE` sends the preamble zeros and counts them.
- `S_START` sends the start bit.
- `S_DATA` sends the data bits and counts them.

Its transitions are:
- `S_PRE` goes to `S_START` after the last preamble bit.
- `S_START` goes to `S_DATA` after one bit.
- `S_DATA` goes to `S_PRE` after the last data bit. This transition is the frame wrap, where the next sample is captured.

Reset enters `S_PRE`.

Top module: `manchester_framer`

## Requirements
- R1: While `rst_n` is low, `line_out` and `sample_taken` are 0. After release, the first frame starts at its first preamble bit. The held sample is cleared, so the first frame carries data 0x0000.
- R2: Every frame is 48 bits long: 31 zero bits, then one start bit of value 1, then 16 data bits. Frames follow one another with no gap, and at least 18 zero bits precede every start bit.
- R3: Data bits are sent most significant bit first. Bit 15 follows the start bit, and bit 0 is the last bit of the frame.
- R4: Each bit lasts two `half_en` intervals. `line_out` equals the bit value in the first half and the inverted bit value in the second half. A 0 is therefore sent as low-then-high and a 1 as high-then-low.
- R5: Every bit has a transition at its midpoint. Each frame holds `line_out` high for exactly 48 of its 96 half-bit intervals.
- R6: `sample_in` is captured in the clock cycle in which `half_en` ends the last data bit of a frame. `sample_taken` is high for exactly that one cycle and at no other time. The captured value is sent in the next frame.
- R7: `line_out` changes only on the clock edge that ends a cycle in which `half_en` is high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | One-cycle strobe at twice the bit rate |
| sample_in | input | 16 | Sample to send in the next frame |
| sample_taken | output | 1 | High in the cycle in which `sample_in` is captured |
| line_out | output | 1 | Manchester-encoded serial line |

## Verification
A new half-bit value appears on `line_out` one clock edge after each cycle in which `half_en` is high. The bench therefore waits for that edge and reads the line 5 ns later, compares it with the next half-bit value queued by the driver, and also confirms, just before the next strobe edge, that the value has held. `sample_taken` is combinational within the strobe cycle, so it is checked at the falling edge of every cycle against the bench's own half-bit count. A sample written during frame k must first appear 64 half-bits after the wrap that ends frame k, since the preamble and start bit come first; the queued frames encode that delay directly.

// File: rtl/mf_pkg.sv
package mf_pkg;

    typedef enum logic [1:0] {
        S_PRE   = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2
    } mf_state_e;

    typedef enum logic [1:0] {
        BS_ZERO = 2'd0,
        BS_ONE  = 2'd1,
        BS_MSB  = 2'd2,
        BS_NEXT = 2'd3
    } mf_bitsel_e;

endpackage

// File: rtl/mf_phase.sv
module mf_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    output logic phase,
    output logic bit_end
);

    // phase 0 = first half of a bit, phase 1 = second half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (half_en) begin
            phase <= ~phase;
        end
    end

    assign bit_end = half_en & phase;

endmodule

// File: rtl/mf_sequencer.sv
module mf_sequencer #(
    parameter int PRE_BITS = 31,
    parameter int DATA_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_end,
    output mf_pkg::mf_state_e    state,
    output mf_pkg::mf_bitsel_e   bit_sel,
    output logic                 load,
    output logic                 shift_en
);
    import mf_pkg::*;

    localparam int MAXC = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CW   = $clog2(MAXC);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    mf_state_e     state_nx;
    logic          wrap;
    logic          step;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            S_PRE: begin
                if (cnt == CW'(PRE_BITS - 1)) begin
                    state_nx = S_START;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            S_START: begin
                state_nx = S_DATA;
                cnt_nx   = '0;
            end
            S_DATA: begin
                if (cnt == CW'(DATA_W - 1)) begin
                    state_nx = S_PRE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = S_PRE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_PRE;
            cnt   <= '0;
        end else if (bit_end) begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs: which value the next bit takes
    always_comb begin
        bit_sel = BS_ZERO;
        wrap    = 1'b0;
        step    = 1'b0;
        unique case (state)
            S_PRE: begin
                bit_sel = (cnt == CW'(PRE_BITS - 1)) ? BS_ONE : BS_ZERO;
            end
            S_START: begin
                bit_sel = BS_MSB;
            end
            S_DATA: begin
                if (cnt == CW'(DATA_W - 1)) begin
                    bit_sel = BS_ZERO;
                    wrap    = 1'b1;
                end else begin
                    bit_sel = BS_NEXT;
                    step    = 1'b1;
                end
            end
            default: begin
                bit_sel = BS_ZERO;
            end
        endcase
    end

    assign load     = bit_end & wrap;
    assign shift_en = bit_end & step;

endmodule

// File: rtl/mf_shifter.sv
module mf_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic              top_bit,
    output logic              after_top
);

    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= din;
        end else if (shift_en) begin
            sr <= {sr[DATA_W-2:0], 1'b0};
        end
    end

    assign top_bit   = sr[DATA_W-1];
    assign after_top = sr[DATA_W-2];

endmodule

// File: rtl/manchester_framer.sv
module manchester_framer #(
    parameter int PRE_BITS = 31,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_en,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sample_taken,
    output logic              line_out
);
    import mf_pkg::*;

    logic       phase;
    logic       bit_end;
    mf_state_e  state;
    mf_bitsel_e bit_sel;
    logic       load;
    logic       shift_en;
    logic       top_bit;
    logic       after_top;
    logic       dat_q;

    mf_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_en (half_en),
        .phase   (phase),
        .bit_end (bit_end)
    );

    mf_sequencer #(
        .PRE_BITS (PRE_BITS),
        .DATA_W   (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_end  (bit_end),
        .state    (state),
        .bit_sel  (bit_sel),
        .load     (load),
        .shift_en (shift_en)
    );

    mf_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift_en  (shift_en),
        .din       (sample_in),
        .top_bit   (top_bit),
        .after_top (after_top)
    );

    // retimed data bit; it changes on the same edge as the phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= 1'b0;
        end else if (bit_end) begin
            unique case (bit_sel)
                BS_ZERO: dat_q <= 1'b0;
                BS_ONE:  dat_q <= 1'b1;
                BS_MSB:  dat_q <= top_bit;
                BS_NEXT: dat_q <= after_top;
                default: dat_q <= 1'b0;
            endcase
        end
    end

    assign sample_taken = load;
    assign line_out     = phase ^ dat_q;

endmodule

// File: rtl/mf_checker.sv
module mf_checker #(
    parameter int PRE_BITS = 31,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_en,
    input logic              phase,
    input logic              dat_q,
    input mf_pkg::mf_state_e state,
    input logic              sample_taken,
    input logic              line_out
);
    import mf_pkg::*;

    localparam int MIN_ZEROS  = 18;
    localparam int FRAME_BITS = PRE_BITS + 1 + DATA_W;
    localparam int BW         = $clog2(FRAME_BITS) + 1;

    logic [7:0]    zrun;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun <= '0;
            bcnt <= '0;
        end else if (half_en && phase) begin
            if (dat_q) zrun <= '0;
            else if (zrun != 8'hFF) zrun <= zrun + 1'b1;
            if (sample_taken) bcnt <= '0;
            else bcnt <= bcnt + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (line_out == 1'b0 && sample_taken == 1'b0)
                else $error("line or pulse active during reset");
        end
    end

    assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_START) |-> (zrun >= 8'(MIN_ZEROS)))
        else $error("too few zeros before start bit");

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_taken |-> (bcnt == BW'(FRAME_BITS - 1)))
        else $error("frame length wrong");

    assert_mid_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && !phase) |=> (line_out != $past(line_out)))
        else $error("no mid-bit transition");

    assert_pulse_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_taken |-> (half_en && phase))
        else $error("sample pulse outside a bit end");

    assert_pulse_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_taken |=> !sample_taken)
        else $error("sample pulse longer than one cycle");

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en |=> $stable(line_out))
        else $error("line moved without strobe");

endmodule

bind manchester_framer mf_checker #(
    .PRE_BITS (PRE_BITS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_en      (half_en),
    .phase        (phase),
    .dat_q        (dat_q),
    .state        (state),
    .sample_taken (sample_taken),
    .line_out     (line_out)
);

// File: tb/manchester_framer_test.sv
`timescale 1ns/1ps
module manchester_framer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_en = 1'b0;
    logic [15:0] sample_in = 16'h0000;
    logic        sample_taken;
    logic        line_out;

    int   vectors = 0;
    int   miscompares = 0;
    logic exp_q[$];
    int   hcnt = 0;
    int   ones = 0;
    bit   gen_on = 1'b0;
    bit   mon_on = 1'b0;
    logic last_val = 1'b0;
    int   div = 0;

    logic [15:0] vals [6] = '{16'hA5C3, 16'hFFFF, 16'h0000,
                              16'h8001, 16'h1234, 16'h7E00};

    manchester_framer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_en      (half_en),
        .sample_in    (sample_in),
        .sample_taken (sample_taken),
        .line_out     (line_out)
    );

    initial forever #10 clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    // driver: push the expected half-bit values of one frame (R2, R3, R4)
    task automatic push_frame(input logic [15:0] d);
        for (int i = 0; i < 31; i++) begin
            exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end
        exp_q.push_back(1'b1);
        exp_q.push_back(1'b0);
        for (int i = 15; i >= 0; i--) begin
            exp_q.push_back(d[i]);
            exp_q.push_back(~d[i]);
        end
    endtask

    task automatic check_half();
        logic e;
        int   h;
        string req;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        h = hcnt % 96;
        req = (h < 64) ? "R2" : "R3";
        vectors++;
        if (line_out !== e) begin
            miscompares++;
            $display("FAIL %s/R4 half %0d: line_out=%b expected %b", req, hcnt, line_out, e);
        end
        last_val = line_out;
        if (line_out === 1'b1) ones++;
        if (h == 95) begin
            vectors++;
            if (ones != 48) begin
                miscompares++;
                $display("FAIL R5 high halves per frame: %0d expected 48", ones);
            end
            ones = 0;
        end
    endtask

    // half-rate strobe generator, one pulse every 4 clocks
    initial forever begin
        @(posedge clk);
        #1;
        half_en = gen_on && (div == 3);
        div = (div + 1) % 4;
    end

    // monitor: new half value is visible after the edge ending a strobe cycle
    initial forever begin
        @(posedge clk);
        if (half_en) begin
            hcnt++;
            if (mon_on) begin
                #5;
                check_half();
            end
        end
    end

    // sample pulse (R6) and hold (R7) checks at the falling edge
    initial forever begin
        @(negedge clk);
        if (mon_on) begin
            logic exp_st;
            exp_st = half_en && (hcnt % 96 == 95);
            vectors++;
            if (sample_taken !== exp_st) begin
                miscompares++;
                $display("FAIL R6 half %0d: sample_taken=%b expected %b", hcnt, sample_taken, exp_st);
            end
            if (half_en) begin
                vectors++;
                if (line_out !== last_val) begin
                    miscompares++;
                    $display("FAIL R7 line moved mid-half: %b expected %b", line_out, last_val);
                end
            end
        end
    end

    task automatic check_reset();
        vectors++;
        if (line_out !== 1'b0 || sample_taken !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 in reset: line_out=%b sample_taken=%b expected 0 0", line_out, sample_taken);
        end
    endtask

    task automatic start_up();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        hcnt = 0;
        ones = 0;
        check_half();   // first half of preamble bit 0 (R1)
        mon_on = 1'b1;
        gen_on = 1'b1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        push_frame(16'h0000);          // R1: cleared sample in first frame
        for (int i = 0; i < 5; i++) push_frame(vals[i]);
        @(negedge clk);
        check_reset();
        start_up();
        for (int i = 0; i < 6; i++) begin
            wait (hcnt == 96 * i + 5);
            @(negedge clk);
            sample_in = vals[i];       // R6: sent in frame i+1
        end
        wait (hcnt == 576);
        mon_on = 1'b0;
        wait (hcnt == 576 + 70);
        @(negedge clk);
        gen_on = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;                  // R1: reset in the middle of the data field
        #1;
        check_reset();
        @(negedge clk);
        check_reset();
        sample_in = 16'h5A5A;
        exp_q.delete();
        push_frame(16'h0000);
        push_frame(16'h5A5A);
        start_up();
        wait (hcnt == 192);
        @(negedge clk);
        mon_on = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule